// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block holds the digital half of a 12-bit successive-approximation analog-to-digital converter. A start request arrives on a pin with no timing relation to the conversion clock. The block synchronises it and raises a hold strobe for the track/hold stage. It then tests the result bits one at a time, from the most significant bit down. For each test it places a code on the DAC input and reads back a single comparator decision. The comparator, DAC and track/hold are analog parts outside this block.

While a conversion runs, an active-low busy pin is low and the result port is kept off the bus. When busy returns high, the host reads the straight-binary result by pulling chip-select and read low together. The output enable `data_oe` is meant to control the pad drivers of a tri-state bus. A mode pin puts the block into a power-save state, and `analog_pd` passes that state on to the analog section. The first conversion after waking only clears the internal state. Its result is discarded and replaced by zero.

Top module: `sar_ctrl_core`

## Requirements
- R1: After reset, `busy_n`=1, `hold`=0, `data_oe`=0, `analog_pd`=0 and `dac_code`=0.
- R2: A conversion starts on a low-to-high change of `conv_start`, which passes through a two-stage synchroniser. `busy_n` falls and `hold` rises at the third rising clock edge after the change. `hold` is 1 exactly while `busy_n` is 0.
- R3: `busy_n` stays low for exactly 26 clock periods. These are one setup cycle, two cycles for each of the 12 bits, and one cycle to store the result.
- R4: Bits are tested from bit 11 (MSB) down to bit 0. One clock after the setup cycle, `dac_code` holds the first trial code 12'h800.
- R5: At each trial the block keeps the tested bit if `cmp_ge`=1 (input at or above the DAC code) and clears it otherwise. The stored result is therefore the straight-binary code of the input, from 0 to 4095.
- R6: `data_oe`=1 and `data_q` carries the result only when `cs_n`=0, `rd_n`=0 and `busy_n`=1. If `cs_n`=1, or if `cs_n`=0 with `rd_n`=1, then `data_oe`=0.
- R7: While `busy_n`=0, `data_oe` stays 0 even when `cs_n` and `rd_n` are both low.
- R8: A rising edge on `conv_start` while `busy_n`=0 is ignored. The current conversion ends on schedule with its own result, and no further conversion follows.
- R9: With the block idle, `run_mode`=0 together with `rd_n`=1 enters power-save, and `analog_pd` becomes 1 one edge later. `run_mode`=0 with `rd_n`=0 does not enter power-save. While in power-save, start edges are ignored.
- R10: When `run_mode` returns to 1, the block leaves power-save one edge later. The next conversion is a dummy that stores 0 as its result. The conversion after it stores a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Asynchronous start request; its rising edge begins a conversion |
| cmp_ge | input | 1 | Comparator decision: 1 when the held input is at or above `dac_code` |
| run_mode | input | 1 | 1 for normal operation, 0 to request power-save |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| dac_code | output | 12 | Trial code sent to the DAC |
| hold | output | 1 | Track/hold strobe, 1 means hold |
| busy_n | output | 1 | Active-low conversion status |
| analog_pd | output | 1 | Power-down request to the analog section |
| data_oe | output | 1 | Output enable for the tri-state data pads |
| data_q | output | 12 | Result value, zero while not enabled |

## Verification
The bench compares the busy-low window with a fixed count of 26 clocks. A sequencer that loses or adds a trial phase would end one cycle early or late. It also checks that the first trial code is 12'h800 and that results come out right at both ends of the range and for alternating bit patterns. A sequencer that tests bits in the wrong order, or uses the wrong decision polarity, would give wrong codes.

A second start edge in the middle of a conversion must not stretch or restart it, and must not leave a conversion queued behind it. The bench also tries to read during a conversion, where a design that only looks at chip-select and read would drive a half-built value. Around power-save, it checks that a low `rd_n` blocks sleep entry, that starts are ignored while asleep, and that the dummy conversion returns 0 before normal results resume.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_TRIAL = 2'd2,
    SEQ_STORE = 2'd3
  } seq_state_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cmp_ge,
  input  logic             discard,
  output logic             busy,
  output logic             store,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result
);
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  seq_state_e       state;
  logic [NBITS-1:0] mask;
  logic             decide;
  logic [NBITS-1:0] kept;
  logic [NBITS-1:0] next_trial;

  always_comb begin
    kept       = cmp_ge ? trial : (trial & ~mask);
    next_trial = kept | (mask >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      trial  <= '0;
      mask   <= '0;
      decide <= 1'b0;
      result <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            state <= SEQ_SETUP;
            trial <= '0;
          end
        end
        SEQ_SETUP: begin
          trial  <= TOP_BIT;
          mask   <= TOP_BIT;
          decide <= 1'b0;
          state  <= SEQ_TRIAL;
        end
        SEQ_TRIAL: begin
          if (!decide) begin
            decide <= 1'b1;
          end else begin
            decide <= 1'b0;
            mask   <= mask >> 1;
            if (mask[0]) begin
              trial <= kept;
              state <= SEQ_STORE;
            end else begin
              trial <= next_trial;
            end
          end
        end
        SEQ_STORE: begin
          result <= discard ? '0 : trial;
          state  <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy  = (state != SEQ_IDLE);
  assign store = (state == SEQ_STORE);
endmodule

// File: rtl/sar_pwr.sv
module sar_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic run_mode,
  input  logic rd_n,
  input  logic busy,
  input  logic store,
  output logic asleep,
  output logic discard
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep  <= 1'b0;
      discard <= 1'b0;
    end else begin
      if (!busy) begin
        if (asleep) begin
          if (run_mode) begin
            asleep  <= 1'b0;
            discard <= 1'b1;
          end
        end else if (!run_mode && rd_n) begin
          asleep <= 1'b1;
        end
      end
      if (store) discard <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_bus.sv
module sar_bus #(
  parameter int unsigned NBITS = 12
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             busy,
  input  logic [NBITS-1:0] result,
  output logic             oe,
  output logic [NBITS-1:0] q
);
  always_comb begin
    oe = ~cs_n & ~rd_n & ~busy;
    q  = oe ? result : '0;
  end
endmodule

// File: rtl/sar_ctrl_core.sv
module sar_ctrl_core
  import sar_pkg::*;
#(
  parameter int unsigned NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             cmp_ge,
  input  logic             run_mode,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [NBITS-1:0] dac_code,
  output logic             hold,
  output logic             busy_n,
  output logic             analog_pd,
  output logic             data_oe,
  output logic [NBITS-1:0] data_q
);
  logic             rise;
  logic             busy;
  logic             store;
  logic             asleep;
  logic             discard;
  logic             go;
  logic [NBITS-1:0] result;

  sar_start_sync #(.STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(conv_start), .rise(rise)
  );

  assign go = rise & ~busy & ~asleep;

  sar_seq #(.NBITS(NBITS)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cmp_ge(cmp_ge), .discard(discard),
    .busy(busy), .store(store), .trial(dac_code), .result(result)
  );

  sar_pwr pwr_i (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .rd_n(rd_n),
    .busy(busy), .store(store), .asleep(asleep), .discard(discard)
  );

  sar_bus #(.NBITS(NBITS)) bus_i (
    .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .result(result),
    .oe(data_oe), .q(data_q)
  );

  assign busy_n    = ~busy;
  assign hold      = busy;
  assign analog_pd = asleep;
endmodule

// File: rtl/sar_ctrl_core_chk.sv
module sar_ctrl_core_chk #(
  parameter int unsigned NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             busy_n,
  input logic             hold,
  input logic             analog_pd,
  input logic             data_oe,
  input logic [NBITS-1:0] dac_code
);
  localparam int unsigned CONV_CYC = 2 * NBITS + 2;
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (!busy_n) low_cnt <= low_cnt + 8'd1;
    else              low_cnt <= '0;
  end

  p_float_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !data_oe);
  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !data_oe);
  p_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && busy_n) |-> data_oe);
  p_len_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_cnt == 8'(CONV_CYC)));
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (low_cnt < 8'(CONV_CYC)));
  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |=> (dac_code == TOP_BIT));
  p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    analog_pd |-> busy_n);
  p_hold_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !analog_pd);
endmodule

bind sar_ctrl_core sar_ctrl_core_chk #(.NBITS(NBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .busy_n(busy_n),
  .hold(hold), .analog_pd(analog_pd), .data_oe(data_oe), .dac_code(dac_code)
);

// File: tb/sar_ctrl_core_tb_top.sv
module sar_ctrl_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        run_mode = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [11:0] vin = '0;
  logic [11:0] dac_code;
  logic        hold, busy_n, analog_pd, data_oe;
  logic [11:0] data_q;
  logic        cmp_ge;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign cmp_ge = (vin >= dac_code);

  sar_ctrl_core dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_ge(cmp_ge),
    .run_mode(run_mode), .cs_n(cs_n), .rd_n(rd_n), .dac_code(dac_code),
    .hold(hold), .busy_n(busy_n), .analog_pd(analog_pd),
    .data_oe(data_oe), .data_q(data_q)
  );

  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    12'd0, 12'd4095, 12'h800, 12'h7FF, 12'd1, 12'hAAA, 12'h555, 12'd1234
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_bus(input logic [11:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    #2;
    chk({req, " oe"}, {31'd0, data_oe}, 32'd1);
    chk({req, " data"}, {20'd0, data_q}, {20'd0, exp});
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic run_conv(input logic [11:0] v, input logic [11:0] exp, input bit disturb);
    vin = v;
    @(negedge clk);
    conv_start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 busy_n falls", {31'd0, busy_n}, 32'd0);
    chk("R2 hold rises", {31'd0, hold}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R4 first trial", {20'd0, dac_code}, 32'h800);
    for (int i = 2; i <= 25; i++) begin
      @(posedge clk); @(negedge clk);
      if (disturb && i == 5)  conv_start = 1'b0;
      if (disturb && i == 10) conv_start = 1'b1;
      if (i == 11) begin cs_n = 1'b0; rd_n = 1'b0; end
      if (i == 12) begin
        #2;
        chk("R7 bus off while busy", {31'd0, data_oe}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b1;
      end
    end
    chk("R3 still busy at 25", {31'd0, busy_n}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R3 ready after 26", {31'd0, busy_n}, 32'd1);
    chk("R2 hold released", {31'd0, hold}, 32'd0);
    conv_start = 1'b0;
    if (disturb) begin
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R8 no queued conversion", {31'd0, busy_n}, 32'd1);
    end
    read_bus(exp, disturb ? "R8 result" : "R5 result");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy_n", {31'd0, busy_n}, 32'd1);
    chk("R1 hold", {31'd0, hold}, 32'd0);
    chk("R1 data_oe", {31'd0, data_oe}, 32'd0);
    chk("R1 analog_pd", {31'd0, analog_pd}, 32'd0);
    chk("R1 dac_code", {20'd0, dac_code}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int k = 0; k < NVEC; k++) run_conv(VEC[k], VEC[k], 1'b0);

    // R6: deselected combinations keep the bus off
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #2;
    chk("R6 cs low rd high", {31'd0, data_oe}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b0; #2;
    chk("R6 cs high rd low", {31'd0, data_oe}, 32'd0);
    chk("R6 q zero when off", {20'd0, data_q}, 32'd0);
    rd_n = 1'b1;

    // R8: retrigger during conversion
    run_conv(12'd3000, 12'd3000, 1'b1);

    // R9: mode low with read low does not sleep
    @(negedge clk); run_mode = 1'b0; rd_n = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R9 no sleep with rd low", {31'd0, analog_pd}, 32'd0);
    rd_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 sleep entered", {31'd0, analog_pd}, 32'd1);
    conv_start = 1'b1;
    repeat (6) @(posedge clk); @(negedge clk);
    chk("R9 start ignored asleep", {31'd0, busy_n}, 32'd1);
    conv_start = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    read_bus(12'd3000, "R9 result kept");

    // R10: wake, dummy, then valid
    @(negedge clk); run_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 awake", {31'd0, analog_pd}, 32'd0);
    @(posedge clk);
    run_conv(12'd2500, 12'd0, 1'b0);
    run_conv(12'd2500, 12'd2500, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule